// File: doc/BRIEF.md
# Up/Down Wiper Position Register

This block keeps the volatile tap position of a 64-step digital potentiometer and decodes it into a one-hot tap-select vector. Exactly one select line is active at any time. Line 0 connects the wiper to the low end of the array, and the top line connects it to the high end.

The position can change in four ways:
- It is reloaded from nonvolatile slot 0 while reset is held and whenever a recall pulse arrives.
- It is loaded in parallel from a chosen data register through a transfer strobe.
- It is written with a value shifted in by the host through a write strobe.
- It is nudged one tap per step pulse while the serial front end holds the block in step mode.

The serial front end keeps step mode active from the step command until chip select rises. The sampled serial input line gives the direction of each step.

The host front end reads the position back through a plain port. No write-protect qualification applies to any path into this register. The resistor array and any analog settling time belong to the surrounding design.

Top module: `wiper_pos_reg`

## Requirements
- R1: While `rst_n` is low, the position register loads the value on `slot0_val` on each clock edge. In the first cycle after release, `pos_q` equals that value.
- R2: A `recall_req` pulse loads `slot0_val` at the next edge. It takes priority over every other source in the same cycle.
- R3: An `xfer_req` pulse loads `xfer_val` at the next edge. It takes priority over a serial write and a step in the same cycle.
- R4: A `wr_req` pulse loads `wr_val` at the next edge. It takes priority over a step in the same cycle.
- R5: A `step_req` pulse with `step_mode` high and `step_up` = 1 raises the position by one at the next edge.
- R6: A `step_req` pulse with `step_mode` high and `step_up` = 0 lowers the position by one at the next edge.
- R7: Steps saturate. An up step at 63 (3Fh) leaves 63, and a down step at 0 leaves 0.
- R8: A `step_req` pulse while `step_mode` is low does not change the position.
- R9: `tap_sel` has exactly one bit set, at bit index equal to `pos_q`. Position 0 selects bit 0 (low end), and 63 selects bit 63 (high end).
- R10: In a cycle with no recall, transfer, write or accepted step, the position holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; position follows slot 0 while low |
| slot0_val | input | 6 | Contents of nonvolatile slot 0 |
| recall_req | input | 1 | Reload pulse from slot 0 |
| xfer_req | input | 1 | Parallel transfer strobe |
| xfer_val | input | 6 | Contents of the selected data register |
| wr_req | input | 1 | Serial write strobe |
| wr_val | input | 6 | Value shifted in by the host |
| step_mode | input | 1 | High while step mode is active (command seen, chip select low) |
| step_req | input | 1 | One pulse per serial clock high phase in step mode |
| step_up | input | 1 | Step direction: 1 toward high end, 0 toward low end |
| pos_q | output | 6 | Current position, for read-back |
| tap_sel | output | 64 | One-hot tap select |

## Verification
The assertions check the following on every cycle:
- The decoder stays one-hot and matches the position.
- An idle cycle leaves the position unchanged.
- Each load source, when it wins, places its own value.
- Accepted steps move by exactly one inside the range and not at all at either end.
- Steps outside step mode do nothing.

Only the bench scenarios show certain behaviour:
- The reset-time recall of slot 0.
- Priority order when several strobes collide in one cycle.
- The end-to-end walk into each saturation limit, seen as the outermost select line staying active.

// File: rtl/wiper_pkg.sv
package wiper_pkg;
   // Which source updated the position in a given cycle
   typedef enum logic [2:0] {
      SRC_NONE   = 3'd0,
      SRC_RECALL = 3'd1,
      SRC_XFER   = 3'd2,
      SRC_WRITE  = 3'd3,
      SRC_STEP   = 3'd4
   } wiper_src_e;

   // Decoder implementation variants
   localparam int DEC_COMPARE = 0;
   localparam int DEC_SHIFT   = 1;
endpackage

// File: rtl/wiper_stepper.sv
module wiper_stepper #(
   parameter int POS_W = 6
) (
   input  logic [POS_W-1:0] pos,
   input  logic             up,
   output logic [POS_W-1:0] next_pos
);
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};
   localparam logic [POS_W-1:0] POS_MIN = '0;

   always_comb begin
      if (up) begin
         next_pos = (pos == POS_MAX) ? pos : pos + 1'b1;
      end else begin
         next_pos = (pos == POS_MIN) ? pos : pos - 1'b1;
      end
   end
endmodule

// File: rtl/wiper_src_arb.sv
module wiper_src_arb
   import wiper_pkg::*;
#(
   parameter int POS_W = 6
) (
   input  logic             recall_req,
   input  logic [POS_W-1:0] recall_val,
   input  logic             xfer_req,
   input  logic [POS_W-1:0] xfer_val,
   input  logic             wr_req,
   input  logic [POS_W-1:0] wr_val,
   input  logic             step_ok,
   input  logic [POS_W-1:0] step_val,
   output logic             load_en,
   output logic [POS_W-1:0] load_val,
   output wiper_src_e       src
);
   // Fixed priority: recall, transfer, write, step
   always_comb begin
      load_en  = 1'b1;
      load_val = '0;
      src      = SRC_NONE;
      if (recall_req) begin
         load_val = recall_val;
         src      = SRC_RECALL;
      end else if (xfer_req) begin
         load_val = xfer_val;
         src      = SRC_XFER;
      end else if (wr_req) begin
         load_val = wr_val;
         src      = SRC_WRITE;
      end else if (step_ok) begin
         load_val = step_val;
         src      = SRC_STEP;
      end else begin
         load_en  = 1'b0;
      end
   end
endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode
   import wiper_pkg::*;
#(
   parameter int POS_W     = 6,
   parameter int DEC_STYLE = DEC_COMPARE,
   localparam int TAPS     = 1 << POS_W
) (
   input  logic [POS_W-1:0] pos,
   output logic [TAPS-1:0]  tap_sel
);
   generate
      if (DEC_STYLE == DEC_SHIFT) begin : g_shift
         assign tap_sel = {{(TAPS-1){1'b0}}, 1'b1} << pos;
      end else begin : g_compare
         for (genvar i = 0; i < TAPS; i++) begin : g_line
            assign tap_sel[i] = (pos == POS_W'(i));
         end
      end
   endgenerate
endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
   import wiper_pkg::*;
#(
   parameter int POS_W     = 6,
   parameter int DEC_STYLE = DEC_COMPARE,
   localparam int TAPS     = 1 << POS_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [POS_W-1:0] slot0_val,
   input  logic             recall_req,
   input  logic             xfer_req,
   input  logic [POS_W-1:0] xfer_val,
   input  logic             wr_req,
   input  logic [POS_W-1:0] wr_val,
   input  logic             step_mode,
   input  logic             step_req,
   input  logic             step_up,
   output logic [POS_W-1:0] pos_q,
   output logic [TAPS-1:0]  tap_sel
);
   localparam logic [POS_W-1:0] POS_MAX = {POS_W{1'b1}};

   generate
      if (POS_W < 1 || POS_W > 10) begin : g_bad_width
         $error("wiper_pos_reg: POS_W must lie in 1..10");
      end
      if (DEC_STYLE != DEC_COMPARE && DEC_STYLE != DEC_SHIFT) begin : g_bad_style
         $error("wiper_pos_reg: unknown DEC_STYLE");
      end
   endgenerate

   logic             step_ok;
   logic [POS_W-1:0] step_val;
   logic             load_en;
   logic [POS_W-1:0] load_val;
   wiper_src_e       src;

   assign step_ok = step_req & step_mode;

   wiper_stepper #(.POS_W(POS_W)) u_step (
      .pos      (pos_q),
      .up       (step_up),
      .next_pos (step_val)
   );

   wiper_src_arb #(.POS_W(POS_W)) u_arb (
      .recall_req (recall_req),
      .recall_val (slot0_val),
      .xfer_req   (xfer_req),
      .xfer_val   (xfer_val),
      .wr_req     (wr_req),
      .wr_val     (wr_val),
      .step_ok    (step_ok),
      .step_val   (step_val),
      .load_en    (load_en),
      .load_val   (load_val),
      .src        (src)
   );

   // Position register: follows slot 0 during reset
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos_q <= slot0_val;
      end else if (load_en) begin
         pos_q <= load_val;
      end
   end

   wiper_tap_decode #(.POS_W(POS_W), .DEC_STYLE(DEC_STYLE)) u_dec (
      .pos     (pos_q),
      .tap_sel (tap_sel)
   );

   // R9
   tap_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(tap_sel) == 1) && tap_sel[pos_q]);

   // R2
   recall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recall_req |=> pos_q == $past(slot0_val));

   // R3
   xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_req && !recall_req) |=> pos_q == $past(xfer_val));

   // R4
   write_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !xfer_req && !recall_req) |=> pos_q == $past(wr_val));

   // R5
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && step_mode && step_up && !wr_req && !xfer_req && !recall_req
       && pos_q != POS_MAX) |=> pos_q == $past(pos_q) + 1'b1);

   // R6
   step_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && step_mode && !step_up && !wr_req && !xfer_req && !recall_req
       && pos_q != '0) |=> pos_q == $past(pos_q) - 1'b1);

   // R7
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step_req && step_mode && !wr_req && !xfer_req && !recall_req
       && ((step_up && pos_q == POS_MAX) || (!step_up && pos_q == '0)))
      |=> $stable(pos_q));

   // R8, R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!recall_req && !xfer_req && !wr_req && !(step_req && step_mode))
      |=> $stable(pos_q));
endmodule

// File: tb/tb_wiper_pos_reg.sv
module tb_wiper_pos_reg;
   localparam int POS_W = 6;
   localparam int TAPS  = 1 << POS_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [POS_W-1:0] slot0_val = '0;
   logic             recall_req = 1'b0;
   logic             xfer_req = 1'b0;
   logic [POS_W-1:0] xfer_val = '0;
   logic             wr_req = 1'b0;
   logic [POS_W-1:0] wr_val = '0;
   logic             step_mode = 1'b0;
   logic             step_req = 1'b0;
   logic             step_up = 1'b0;
   logic [POS_W-1:0] pos_q;
   logic [TAPS-1:0]  tap_sel;

   int errors = 0;
   int checks = 0;

   always #2 clk = ~clk;

   wiper_pos_reg #(.POS_W(POS_W)) dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot0_val  (slot0_val),
      .recall_req (recall_req),
      .xfer_req   (xfer_req),
      .xfer_val   (xfer_val),
      .wr_req     (wr_req),
      .wr_val     (wr_val),
      .step_mode  (step_mode),
      .step_req   (step_req),
      .step_up    (step_up),
      .pos_q      (pos_q),
      .tap_sel    (tap_sel)
   );

   task automatic chk(input string req, input logic [POS_W-1:0] exp);
      logic [TAPS-1:0] exp_sel;
      exp_sel = {{(TAPS-1){1'b0}}, 1'b1} << exp;
      checks++;
      if (pos_q !== exp) begin
         errors++;
         $display("FAIL %s: pos_q=%0h expected %0h", req, pos_q, exp);
      end
      checks++;
      if (tap_sel !== exp_sel) begin
         errors++;
         $display("FAIL %s R9: tap_sel=%h expected %h", req, tap_sel, exp_sel);
      end
   endtask

   // One cycle with the given strobes, then strobes cleared
   task automatic cyc(input logic rc, input logic xf, input logic [POS_W-1:0] xv,
                      input logic wr, input logic [POS_W-1:0] wv,
                      input logic st, input logic up, input logic md);
      @(negedge clk);
      recall_req = rc; xfer_req = xf; xfer_val = xv;
      wr_req = wr; wr_val = wv; step_req = st; step_up = up; step_mode = md;
      @(posedge clk);
      #1;
      @(negedge clk);
      recall_req = 0; xfer_req = 0; wr_req = 0; step_req = 0;
   endtask

   task automatic t_reset();
      slot0_val = 6'h15;
      rst_n = 0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      #1 chk("R1 reset recall", 6'h15);
   endtask

   task automatic t_write();
      cyc(0, 0, 0, 1, 6'h3F, 0, 0, 0); chk("R4 write high end", 6'h3F);
      cyc(0, 0, 0, 1, 6'h00, 0, 0, 0); chk("R4 write low end", 6'h00);
   endtask

   task automatic t_step_up();
      cyc(0, 0, 0, 1, 6'h3D, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 1, 1); chk("R5 step up", 6'h3E);
      cyc(0, 0, 0, 0, 0, 1, 1, 1); chk("R5 step up to max", 6'h3F);
      cyc(0, 0, 0, 0, 0, 1, 1, 1); chk("R7 saturate high", 6'h3F);
   endtask

   task automatic t_step_down();
      cyc(0, 0, 0, 1, 6'h02, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 0, 1); chk("R6 step down", 6'h01);
      cyc(0, 0, 0, 0, 0, 1, 0, 1); chk("R6 step down to min", 6'h00);
      cyc(0, 0, 0, 0, 0, 1, 0, 1); chk("R7 saturate low", 6'h00);
   endtask

   task automatic t_mode_off();
      cyc(0, 0, 0, 1, 6'h20, 0, 0, 0);
      cyc(0, 0, 0, 0, 0, 1, 1, 0); chk("R8 up step outside mode", 6'h20);
      cyc(0, 0, 0, 0, 0, 1, 0, 0); chk("R8 down step outside mode", 6'h20);
   endtask

   task automatic t_idle();
      repeat (5) @(posedge clk);
      #1 chk("R10 idle hold", 6'h20);
   endtask

   task automatic t_xfer();
      cyc(0, 1, 6'h2A, 0, 0, 0, 0, 0); chk("R3 transfer", 6'h2A);
      cyc(0, 1, 6'h11, 1, 6'h05, 1, 1, 1); chk("R3 transfer beats write and step", 6'h11);
      cyc(0, 0, 0, 1, 6'h09, 1, 1, 1); chk("R4 write beats step", 6'h09);
   endtask

   task automatic t_recall();
      slot0_val = 6'h07;
      cyc(1, 1, 6'h33, 1, 6'h22, 1, 0, 1); chk("R2 recall beats all", 6'h07);
      slot0_val = 6'h3C;
      cyc(1, 0, 0, 0, 0, 0, 0, 0); chk("R2 recall alone", 6'h3C);
   endtask

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_write();
      t_step_up();
      t_step_down();
      t_mode_off();
      t_idle();
      t_xfer();
      t_recall();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule